// File: doc/BRIEF.md
# Dual-Buffer Page Flash Write Sequencer

This block is the host-side SPI master that puts data into a serial page flash with two on-chip SRAM buffers. Each request names a page, a starting byte column inside the buffer and a byte count. The request is either a plain write or a read-modify-write of a page that already holds data. The sequencer emits the flash commands that carry out the request. It pulls the payload bytes one at a time from a byte input, and a one-cycle take strobe marks each byte it consumes.

A plain write loads the current buffer and then programs it into the page with erase. Because the buffer choice flips after every program, the next plain write can load the other buffer while the array is still busy. A modify first moves the page into a buffer, then overwrites the chosen bytes, then programs the buffer back. Before every command that uses the array, the sequencer reads the status byte until its ready bit is set. To keep within the flash endurance rule, one auto page rewrite is inserted after every REFRESH_EVERY programs. The rewrite targets a rolling page pointer, which then advances.

The serial clock is the system clock divided by 2*HALF. It idles low (SPI mode 0). Chip-select setup, hold and minimum high time are each set in system clock cycles by a parameter.

Top module: `page_writer`

## Requirements
- R1: After reset, cs_n is 1, sck is 0 and req_ready is 1.
- R2: A buffer load is sent as opcode 84h (buffer A) or 87h (buffer B), then three address bytes carrying the start column in bits 8..0 with the upper 15 bits 0, then exactly req_len payload bytes. The payload bytes are taken from wr_data in order, and wr_take pulses once for each byte.
- R3: Before a transfer, program or rewrite command, and before the buffer load of a modify, status opcode 57h is sent and the first returned bit (bit 7) is read. Polling repeats until that bit is 1, so none of these commands starts while the flash is busy.
- R4: A program with erase is sent as opcode 83h (buffer A) or 86h (buffer B). The 24 address bits after it are 3 zero bits, then the page number MSB first, then 9 zero bits.
- R5: The first request after reset uses buffer A, and the buffer flips after every program. The buffer load of a plain write is sent without a prior status poll, so it can overlap the previous program.
- R6: A modify request sends, in order, a transfer of the page into the current buffer (53h for A, 55h for B, page address as in R4), then the buffer load of R2, then the program of R4, all on the same buffer.
- R7: After every REFRESH_EVERY-th program, an auto page rewrite is sent at the refresh pointer. Its address has the layout of R4. It uses the buffer that was just programmed (58h for A, 59h for B). The pointer starts at 0 and increments by 1 after each rewrite.
- R8: sck is 0 whenever cs_n is 1. Each sck level lasts HALF clock cycles. Every byte is sent MSB first, with mosi stable at each rising sck edge, and miso is sampled on rising sck edges.
- R9: cs_n stays low for at least CS_SETUP cycles before the first sck rise. It rises with sck low. It stays high for at least CS_GAP cycles between two commands.
- R10: req_ready is 1 only when no request is in progress, including any pending rewrite. A req_valid seen while req_ready is 0 causes no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when req_ready is 1 |
| req_modify | input | 1 | 1 selects read-modify-write, 0 selects plain write |
| req_page | input | PAGE_W | Target page |
| req_col | input | COL_W | First buffer byte to load |
| req_len | input | LEN_W | Number of payload bytes, at least 1 |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| wr_data | input | 8 | Next payload byte |
| wr_take | output | 1 | wr_data consumed on this clock |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The assertions check four things on every cycle: the serial clock stays low while select is high, each serial clock level lasts more than one cycle, select rises only with the serial clock low, and req_ready and wr_take occur only in the right bus state. Some behaviour needs a flash model that stays busy for hundreds of cycles after each array command, and only the bench scenarios can show it. This covers the command order for plain and modify requests and the alternation of the two buffers. It also covers the overlap of a load with the previous program, repeated polling until the ready bit is set, the byte layout of each address, and the rewrite opcode and page after every third program.

// File: rtl/page_writer.sv
module page_writer #(
  parameter int PAGE_W        = 12,
  parameter int COL_W         = 9,
  parameter int LEN_W         = 9,
  parameter int HALF          = 5,
  parameter int CS_SETUP      = 3,
  parameter int CS_HOLD       = 3,
  parameter int CS_GAP        = 25,
  parameter int REFRESH_EVERY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_modify,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int BI_W = LEN_W + 2;
  localparam int CW   = $clog2(CS_GAP + CS_SETUP + CS_HOLD + HALF + 1);
  localparam int RW   = $clog2(REFRESH_EVERY + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_GAP} st_t;
  typedef enum logic [1:0] {PH_XFER, PH_LOAD, PH_PROG, PH_RFSH} ph_t;

  st_t st;
  ph_t ph;
  logic              busy, modify, buf_b, is_poll, rdy_seen;
  logic [PAGE_W-1:0] page, rptr;
  logic [COL_W-1:0]  col;
  logic [LEN_W-1:0]  len;
  logic [RW-1:0]     pcnt;
  logic [CW-1:0]     cnt;
  logic [2:0]        bits;
  logic [7:0]        sh, rx, opc, nxt;
  logic [BI_W-1:0]   bi, lastb;
  logic [23:0]       addr;

  wire need_poll = !rdy_seen && !(ph == PH_LOAD && !modify);
  wire tick      = (st == S_SHIFT) && (cnt == CW'(HALF - 1));
  wire more      = tick && sck && (bits == 3'd7) && (bi != lastb);

  assign wr_take   = more && !is_poll && (bi >= BI_W'(3));
  assign req_ready = !busy;
  assign mosi      = sh[7];

  always_comb begin
    case (ph)
      PH_XFER: begin opc = buf_b ? 8'h55 : 8'h53; addr = 24'({page, {COL_W{1'b0}}}); end
      PH_LOAD: begin opc = buf_b ? 8'h87 : 8'h84; addr = 24'(col); end
      PH_PROG: begin opc = buf_b ? 8'h86 : 8'h83; addr = 24'({page, {COL_W{1'b0}}}); end
      default: begin opc = buf_b ? 8'h58 : 8'h59; addr = 24'({rptr, {COL_W{1'b0}}}); end
    endcase
    if (is_poll)                nxt = 8'h00;
    else if (bi == BI_W'(0))    nxt = addr[23:16];
    else if (bi == BI_W'(1))    nxt = addr[15:8];
    else if (bi == BI_W'(2))    nxt = addr[7:0];
    else                        nxt = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_LOAD; busy <= 1'b0; modify <= 1'b0; buf_b <= 1'b0;
      is_poll <= 1'b0; rdy_seen <= 1'b0; page <= '0; rptr <= '0; col <= '0;
      len <= '0; pcnt <= '0; cnt <= '0; bits <= '0; sh <= '0; rx <= '0;
      bi <= '0; lastb <= '0; cs_n <= 1'b1; sck <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (!busy) begin
            if (req_valid) begin
              busy <= 1'b1; modify <= req_modify; page <= req_page;
              col <= req_col; len <= req_len; rdy_seen <= 1'b0;
              ph <= req_modify ? PH_XFER : PH_LOAD;
            end
          end else begin
            st <= S_SETUP; cs_n <= 1'b0; cnt <= '0; bi <= '0; bits <= '0;
            is_poll <= need_poll;
            sh <= need_poll ? 8'h57 : opc;
            lastb <= need_poll ? BI_W'(1)
                   : (ph == PH_LOAD ? BI_W'(len) + BI_W'(3) : BI_W'(3));
          end
        S_SETUP:
          if (cnt == CW'(CS_SETUP - 1)) begin st <= S_SHIFT; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_SHIFT:
          if (tick) begin
            cnt <= '0;
            sck <= ~sck;
            if (!sck) rx <= {rx[6:0], miso};
            else if (bits == 3'd7) begin
              bits <= '0;
              if (more) begin bi <= bi + 1'b1; sh <= nxt; end
              else st <= S_HOLD;
            end else begin
              bits <= bits + 1'b1;
              sh <= {sh[6:0], 1'b0};
            end
          end else cnt <= cnt + 1'b1;
        S_HOLD:
          if (cnt == CW'(CS_HOLD - 1)) begin st <= S_GAP; cs_n <= 1'b1; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default:
          if (cnt == CW'(CS_GAP - 1)) begin
            st <= S_IDLE;
            cnt <= '0;
            if (is_poll) rdy_seen <= rx[7];
            else begin
              rdy_seen <= 1'b0;
              case (ph)
                PH_XFER: ph <= PH_LOAD;
                PH_LOAD: ph <= PH_PROG;
                PH_PROG: begin
                  buf_b <= ~buf_b;
                  if (pcnt == RW'(REFRESH_EVERY - 1)) begin pcnt <= '0; ph <= PH_RFSH; end
                  else begin pcnt <= pcnt + 1'b1; busy <= 1'b0; end
                end
                default: begin rptr <= rptr + 1'b1; busy <= 1'b0; end
              endcase
            end
          end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R8
  AST_SCK_HALF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sck) || $fell(sck)) |=> $stable(sck)); // R8
  AST_CS_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> !sck); // R9
  AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> cs_n); // R10
  AST_TAKE_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (!cs_n && !req_ready)); // R2
endmodule

// File: tb/tb_page_writer.sv
module tb_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2, SETUP = 2, HOLD = 2, GAP = 6, NREF = 3, BUSY_T = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_modify = 1'b0;
  logic [11:0] req_page = '0;
  logic [8:0] req_col = '0, req_len = '0;
  logic req_ready, wr_take, cs_n, sck, mosi;
  logic miso = 1'b0;
  logic [7:0] wr_data;

  page_writer #(.PAGE_W(12), .COL_W(9), .LEN_W(9), .HALF(HALF), .CS_SETUP(SETUP),
    .CS_HOLD(HOLD), .CS_GAP(GAP), .REFRESH_EVERY(NREF)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_modify(req_modify),
    .req_page(req_page), .req_col(req_col), .req_len(req_len), .req_ready(req_ready),
    .wr_data(wr_data), .wr_take(wr_take), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vec = 0, bad = 0, fill = 0, dptr = 0, takes = 0, polls = 0;
  logic [7:0] pool [0:63];
  logic done = 1'b0;
  assign wr_data = pool[dptr];
  always @(posedge clk) if (wr_take) begin dptr <= dptr + 1; takes <= takes + 1; end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model state
  int e_buf = 0, e_cnt = 0;
  logic [11:0] e_rptr = '0;
  logic [7:0] e_op[$];
  logic [23:0] e_ad[$];
  int e_n[$], e_d0[$];
  string e_tag[$];
  logic loadb[$];

  task automatic push(input logic [7:0] op, input logic [23:0] ad, input int n, input int d0, input string tag);
    e_op.push_back(op); e_ad.push_back(ad); e_n.push_back(n); e_d0.push_back(d0); e_tag.push_back(tag);
  endtask

  task automatic expect_req(input bit m, input logic [11:0] pg, input logic [8:0] c, input int n, input int d0);
    if (m) push(e_buf ? 8'h55 : 8'h53, {3'b0, pg, 9'b0}, 0, 0, "R6");
    push(e_buf ? 8'h87 : 8'h84, {15'b0, c}, n, d0, m ? "R6" : "R2");
    push(e_buf ? 8'h86 : 8'h83, {3'b0, pg, 9'b0}, 0, 0, "R4");
    e_buf ^= 1;
    e_cnt++;
    if (e_cnt == NREF) begin
      e_cnt = 0;
      push(e_buf ? 8'h58 : 8'h59, {3'b0, e_rptr, 9'b0}, 0, 0, "R7");
      e_rptr++;
    end
  endtask

  // flash model, sampled mid-cycle
  logic psck = 1'b0, pcs = 1'b1, op_busy = 1'b0, seen_cmd = 1'b0, rose_once = 1'b0;
  logic [7:0] sr = '0, stat;
  logic [7:0] got[$];
  int bitc = 0, busy_cnt = 0, hi_cnt = 0, lo_cnt = 0, since = 0;

  task automatic finish_cmd();
    bit arr;
    if (got.size() > 0 && got[0] == 8'h57) begin polls++; return; end
    if (e_op.size() == 0) begin
      check(0, "R10", "unexpected command opcode", got.size() > 0 ? got[0] : 0, 0);
      return;
    end
    begin
      logic [7:0] op; logic [23:0] ad; int n, d0; string tag; bit ok;
      op = e_op.pop_front(); ad = e_ad.pop_front(); n = e_n.pop_front();
      d0 = e_d0.pop_front(); tag = e_tag.pop_front();
      check(got.size() == 4 + n, tag, "command length", got.size(), 4 + n);
      check(got.size() > 0 && got[0] == op, tag, "opcode", got.size() > 0 ? got[0] : 0, op);
      if (got.size() >= 4) check({got[1], got[2], got[3]} == ad, tag, "address", {got[1], got[2], got[3]}, ad);
      ok = 1;
      for (int i = 0; i < n && 4 + i < got.size(); i++) if (got[4 + i] != pool[d0 + i]) ok = 0;
      if (n > 0) check(ok, tag, "payload bytes", ok, 1);
      arr = (op != 8'h84 && op != 8'h87);
      if (arr || tag == "R6") check(!op_busy, "R3", "command issued while busy", op_busy, 0);
      if (!arr) loadb.push_back(op_busy);
      if (arr) busy_cnt = BUSY_T;
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (busy_cnt > 0) busy_cnt--;
    check(!(cs_n && sck), "R8", "sck high while deselected", sck, 0);
    since++;
    if (!cs_n && pcs) begin
      if (seen_cmd) check(hi_cnt >= GAP, "R9", "cs high time", hi_cnt, GAP);
      bitc = 0; got.delete(); lo_cnt = 0; rose_once = 0;
    end
    if (!cs_n && !rose_once) lo_cnt++;
    if (!cs_n && sck && !psck) begin
      if (!rose_once) check(lo_cnt > SETUP, "R9", "cs setup cycles", lo_cnt, SETUP + 1);
      rose_once = 1;
      sr = {sr[6:0], mosi};
      bitc++;
      if (bitc % 8 == 0) begin got.push_back(sr); if (bitc == 8) op_busy = (busy_cnt > 0); end
      since = 0;
    end
    if (!cs_n && !sck && psck) begin
      check(since == HALF, "R8", "sck high duration", since, HALF);
      since = 0;
      if (bitc >= 8 && got.size() > 0 && got[0] == 8'h57) begin
        stat = {busy_cnt == 0, 7'b0100000};
        miso = stat[7 - ((bitc - 8) % 8)];
      end
    end
    if (cs_n && !pcs) begin finish_cmd(); hi_cnt = 0; seen_cmd = 1; end
    if (cs_n) hi_cnt++;
    psck = sck; pcs = cs_n;
  end

  task automatic summary();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  task automatic start_req(input bit m, input logic [11:0] pg, input logic [8:0] c, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) pool[fill + i] = seed + 8'(i * 37);
    expect_req(m, pg, c, n, fill);
    fill += n;
    @(negedge clk);
    req_valid = 1'b1; req_modify = m; req_page = pg; req_col = c; req_len = 9'(n);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) pool[i] = '0;
    repeat (4) @(negedge clk);
    check(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
    check(sck == 1'b0, "R1", "sck after reset", sck, 0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    rst_n = 1'b1;

    start_req(0, 12'h005, 9'h000, 4, 8'h11); wait_done();
    start_req(0, 12'hFFF, 9'h107, 3, 8'h40); wait_done();
    check(loadb.size() > 1 && loadb[1] == 1'b1, "R5", "second load overlaps program",
          loadb.size() > 1 ? int'(loadb[1]) : -1, 1);
    check(polls > 0, "R3", "status polls seen", polls, 1);

    start_req(1, 12'h123, 9'h005, 2, 8'h80);
    repeat (20) @(negedge clk);
    check(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
    req_valid = 1'b1; req_modify = 1'b0; req_page = 12'hABC; req_len = 9'd1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();

    start_req(0, 12'h001, 9'h0FF, 1, 8'h21); wait_done();
    start_req(0, 12'h002, 9'h000, 2, 8'h33); wait_done();
    start_req(1, 12'h003, 9'h010, 5, 8'hC4); wait_done();
    repeat (GAP + 4) @(negedge clk);

    check(e_op.size() == 0, "R7", "expected commands left over", e_op.size(), 0);
    check(takes == fill, "R2", "wr_take pulses", takes, fill);
    check(polls > 6, "R3", "repeated polling while busy", polls, 7);
    summary();
    $finish;
  end
endmodule